// File: doc/BRIEF.md
# Pipelined First-Order PLL Loop Filter

This block is the loop filter of a second-order phase-locked loop. It is a fixed-point filter with one pole and one zero. It takes signed phase-error samples from a decimator and turns them into a signed 32-bit frequency control word for a numerically controlled oscillator. The filter only runs when the decimator raises its sample strobe. Between strobes every register holds its value.

Inside, the filter keeps one state word. On each strobe the new state is the input minus the pole coefficient times the old state. The numerator adds the zero coefficient times the old state to that new state, and the result is then scaled by the loop gain. A pipeline register sits between this zero sum and the gain multiply, so each clock-to-clock path passes through only one multiplier. The price is one extra update period of loop delay. Each product is cut back to the 32-bit datapath by dropping its fraction guard bits and its redundant sign bit.

All three coefficients come in as plain input words. Software or a higher-level controller sets them from the wanted natural frequency and damping.

Top module: `loop_filter_top`

## Requirements
- R1: A synchronous active-high `rst` clears the state, the pipeline register and the output register. `ctrl_word` reads 0 and `ctrl_valid` reads 0 in the cycle after reset, even when reset is applied in the middle of a run.
- R2: The state word has 1 sign bit, 23 integer bits and 8 fraction bits. On each strobe it becomes x·2^8 − floor(a·w/2^15), where x is the signed 8-bit `phase_err`, a is the signed Q1.15 `pole_coef` and w is the previous state.
- R3: On each strobe the zero sum is the new state plus floor(b·w/2^15). Here b is the signed Q1.15 `zero_coef` and w is the previous state, the same one used in R2.
- R4: On strobe n, `ctrl_word` takes floor(g·s/2^15), where s is the zero sum from strobe n−1 and g is the signed Q9.7 `gain_coef` present at strobe n. The output is therefore one update period behind the unpipelined filter.
- R5: While `sample_stb` is low, no register changes: `ctrl_word` stays stable.
- R6: `ctrl_valid` is high for exactly the cycle that follows a strobe edge. This holds from the second strobe after reset onward. It is low at every other time.
- R7: The state adder, the zero adder and all three products never overflow, as long as the coefficients stay in their legal ranges. This holds even with a constant full-scale input and the pole at −32767/32768.
- R8: The legal coefficient ranges are −32768 < `pole_coef` < 0, −32768 < `zero_coef` < 0 and `gain_coef` > 0, all as signed 16-bit words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_stb | input | 1 | Decimated update strobe |
| phase_err | input | 8 | Signed integer phase-error sample |
| pole_coef | input | 16 | Pole coefficient a, signed Q1.15 |
| zero_coef | input | 16 | Zero coefficient b, signed Q1.15 |
| gain_coef | input | 16 | Loop gain g, signed Q9.7 |
| ctrl_word | output | 32 | Signed integer control word |
| ctrl_valid | output | 1 | Pulse marking a fresh control word |

## Verification
The no-overflow assertions rely on the coefficients staying inside the R8 ranges at every strobe. Under those ranges the pole never reaches −1 and the state stays below 2^31 in magnitude. The bench only programs coefficient sets that lie strictly inside those ranges. This includes the extreme near-integrator pole together with the largest gain, driven by long runs of constant −128 and +127 inputs. The bench does not drive the coefficient inputs with out-of-range values, because those would break the sizing that the overflow checks rely on.

// File: rtl/lf_pkg.sv
package lf_pkg;
   localparam int unsigned LF_IN_W    = 8;
   localparam int unsigned LF_ACC_W   = 32;
   localparam int unsigned LF_FRAC_W  = 8;
   localparam int unsigned LF_COEF_W  = 16;
   localparam int unsigned LF_CF_FRAC = 15;
   localparam int unsigned LF_G_FRAC  = 7;
endpackage

// File: rtl/lf_frac_mul.sv
module lf_frac_mul #(
   parameter int unsigned DW    = 32,
   parameter int unsigned CW    = 16,
   parameter int unsigned SHIFT = 15
) (
   input  logic signed [DW-1:0] din,
   input  logic signed [CW-1:0] coef,
   output logic signed [DW-1:0] prod,
   output logic                 ovf
);
   localparam int unsigned PW  = DW + CW;
   localparam int unsigned TOP = SHIFT + DW - 1;

   generate
      if (TOP > PW - 1) begin : g_bad_shift
         $error("lf_frac_mul: SHIFT too large for product width");
      end
      if (SHIFT == 0) begin : g_bad_zero
         $error("lf_frac_mul: SHIFT must be non-zero");
      end
   endgenerate

   logic signed [PW-1:0] full;
   logic [SHIFT-1:0]     unused_lo;
   logic [PW-1-TOP:0]    upper;

   assign full      = PW'(din) * PW'(coef);
   assign prod      = full[TOP:SHIFT];
   assign unused_lo = full[SHIFT-1:0];
   assign upper     = full[PW-1:TOP];
   assign ovf       = !((&upper) || !(|upper));
endmodule

// File: rtl/lf_state_stage.sv
module lf_state_stage #(
   parameter int unsigned ACC_W   = 32,
   parameter int unsigned COEF_W  = 16,
   parameter int unsigned CF_FRAC = 15
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     en,
   input  logic signed [ACC_W-1:0]  x_ext,
   input  logic signed [COEF_W-1:0] a_coef,
   input  logic signed [COEF_W-1:0] b_coef,
   output logic signed [ACC_W-1:0]  zsum
);
   logic signed [ACC_W-1:0] w_q, w_nxt, pa, pb;
   logic                    ovf_a, ovf_b;

   lf_frac_mul #(.DW(ACC_W), .CW(COEF_W), .SHIFT(CF_FRAC)) u_pole (
      .din(w_q), .coef(a_coef), .prod(pa), .ovf(ovf_a));
   lf_frac_mul #(.DW(ACC_W), .CW(COEF_W), .SHIFT(CF_FRAC)) u_zero (
      .din(w_q), .coef(b_coef), .prod(pb), .ovf(ovf_b));

   assign w_nxt = x_ext - pa;
   assign zsum  = w_nxt + pb;

   always_ff @(posedge clk) begin
      if (rst)     w_q <= '0;
      else if (en) w_q <= w_nxt;
   end

   // R7: the state adder keeps the sign that the operands allow
   a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
      en && (x_ext[ACC_W-1] != pa[ACC_W-1]) |-> (w_nxt[ACC_W-1] == x_ext[ACC_W-1]));
   a_r7_zero_no_overflow: assert property (@(posedge clk) disable iff (rst)
      en && (w_nxt[ACC_W-1] == pb[ACC_W-1]) |-> (zsum[ACC_W-1] == pb[ACC_W-1]));
   a_r7_prod_fits: assert property (@(posedge clk) disable iff (rst)
      en |-> !ovf_a && !ovf_b);
   // R5: the state only moves on a strobe
   a_r5_state_hold: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(w_q));
endmodule

// File: rtl/lf_gain_stage.sv
module lf_gain_stage #(
   parameter int unsigned ACC_W  = 32,
   parameter int unsigned COEF_W = 16,
   parameter int unsigned SHIFT  = 15
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     en,
   input  logic signed [ACC_W-1:0]  zsum,
   input  logic signed [COEF_W-1:0] g_coef,
   output logic signed [ACC_W-1:0]  y
);
   logic signed [ACC_W-1:0] z_q, gp;
   logic                    ovf_g;

   lf_frac_mul #(.DW(ACC_W), .CW(COEF_W), .SHIFT(SHIFT)) u_gain (
      .din(z_q), .coef(g_coef), .prod(gp), .ovf(ovf_g));

   always_ff @(posedge clk) begin
      if (rst) begin
         z_q <= '0;
         y   <= '0;
      end else if (en) begin
         z_q <= zsum;
         y   <= gp;
      end
   end

   // R7: the gain product fits the output word
   a_r7_gain_fits: assert property (@(posedge clk) disable iff (rst)
      en |-> !ovf_g);
   // R5: the output holds between strobes
   a_r5_out_hold: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(y));
   // R4: a zero pipeline stage yields a zero output on the next update
   a_r4_pipe_zero: assert property (@(posedge clk) disable iff (rst)
      en && (z_q == '0) |=> (y == '0));
endmodule

// File: rtl/loop_filter_top.sv
module loop_filter_top
   import lf_pkg::*;
#(
   parameter int unsigned IN_W    = LF_IN_W,
   parameter int unsigned ACC_W   = LF_ACC_W,
   parameter int unsigned FRAC_W  = LF_FRAC_W,
   parameter int unsigned COEF_W  = LF_COEF_W,
   parameter int unsigned CF_FRAC = LF_CF_FRAC,
   parameter int unsigned G_FRAC  = LF_G_FRAC
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     sample_stb,
   input  logic signed [IN_W-1:0]   phase_err,
   input  logic signed [COEF_W-1:0] pole_coef,
   input  logic signed [COEF_W-1:0] zero_coef,
   input  logic signed [COEF_W-1:0] gain_coef,
   output logic signed [ACC_W-1:0]  ctrl_word,
   output logic                     ctrl_valid
);
   localparam int unsigned EXT_W   = ACC_W - IN_W - FRAC_W;
   localparam int unsigned G_SHIFT = FRAC_W + G_FRAC;

   generate
      if (ACC_W < IN_W + FRAC_W + 1) begin : g_bad_acc
         $error("loop_filter_top: ACC_W too small for input and fraction");
      end
      if (CF_FRAC != COEF_W - 1) begin : g_bad_cf
         $error("loop_filter_top: pole/zero coefficients must be pure fractions");
      end
      if (G_FRAC >= COEF_W) begin : g_bad_g
         $error("loop_filter_top: gain fraction exceeds coefficient width");
      end
   endgenerate

   logic signed [ACC_W-1:0] x_ext, zsum;
   logic                    primed;

   assign x_ext = {{EXT_W{phase_err[IN_W-1]}}, phase_err, {FRAC_W{1'b0}}};

   lf_state_stage #(.ACC_W(ACC_W), .COEF_W(COEF_W), .CF_FRAC(CF_FRAC)) u_state (
      .clk(clk), .rst(rst), .en(sample_stb), .x_ext(x_ext),
      .a_coef(pole_coef), .b_coef(zero_coef), .zsum(zsum));

   lf_gain_stage #(.ACC_W(ACC_W), .COEF_W(COEF_W), .SHIFT(G_SHIFT)) u_gain (
      .clk(clk), .rst(rst), .en(sample_stb), .zsum(zsum),
      .g_coef(gain_coef), .y(ctrl_word));

   always_ff @(posedge clk) begin
      if (rst) begin
         primed     <= 1'b0;
         ctrl_valid <= 1'b0;
      end else begin
         if (sample_stb) primed <= 1'b1;
         ctrl_valid <= sample_stb && primed;
      end
   end

   // R6: a valid pulse always traces back to a strobe
   a_r6_valid_after_stb: assert property (@(posedge clk) disable iff (rst)
      ctrl_valid |-> $past(sample_stb));
   // R6: no valid without a strobe
   a_r6_no_stb_no_valid: assert property (@(posedge clk) disable iff (rst)
      !sample_stb |=> !ctrl_valid);
   // R8: coefficients inside their legal ranges at every update
   a_r8_coef_range: assert property (@(posedge clk) disable iff (rst)
      sample_stb |-> (pole_coef < 0) && (pole_coef != {1'b1, {(COEF_W-1){1'b0}}})
                  && (zero_coef < 0) && (zero_coef != {1'b1, {(COEF_W-1){1'b0}}})
                  && (gain_coef > 0));
   // R1: after reset the output is cleared
   a_r1_reset_clear: assert property (@(posedge clk)
      $past(rst) |-> (ctrl_word == '0) && !ctrl_valid);
endmodule

// File: tb/sim_loop_filter_top.sv
module sim_loop_filter_top;
   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               sample_stb = 1'b0;
   logic signed [7:0]  phase_err = '0;
   logic signed [15:0] pole_coef = -16'sd1;
   logic signed [15:0] zero_coef = -16'sd1;
   logic signed [15:0] gain_coef = 16'sd1;
   logic signed [31:0] ctrl_word;
   logic               ctrl_valid;

   int checks = 0;
   int fails  = 0;
   int nstb   = 0;
   longint mw = 0, mz = 0, my = 0;

   always #2 clk = ~clk;

   loop_filter_top u0 (
      .clk(clk), .rst(rst), .sample_stb(sample_stb), .phase_err(phase_err),
      .pole_coef(pole_coef), .zero_coef(zero_coef), .gain_coef(gain_coef),
      .ctrl_word(ctrl_word), .ctrl_valid(ctrl_valid));

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      sample_stb = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      mw = 0; mz = 0; my = 0; nstb = 0;
      chk("R1 ctrl_word after reset", longint'(ctrl_word), 0);
      chk("R1 ctrl_valid after reset", longint'(ctrl_valid), 0);
   endtask

   // R2 R3 R4: bench model of one update, applied at the strobe edge
   task automatic step(input logic signed [7:0] xv, input int gap);
      longint wn, s, yn;
      phase_err  = xv;
      sample_stb = 1'b1;
      wn = longint'(xv) * 256 - ((longint'(pole_coef) * mw) >>> 15);
      s  = wn + ((longint'(zero_coef) * mw) >>> 15);
      yn = (longint'(gain_coef) * mz) >>> 15;
      @(negedge clk);
      sample_stb = 1'b0;
      mw = wn; mz = s; my = yn; nstb++;
      chk("R4 ctrl_word after strobe", longint'(ctrl_word), my);
      chk("R6 ctrl_valid after strobe", longint'(ctrl_valid), (nstb >= 2) ? 1 : 0);
      for (int k = 0; k < gap; k++) begin
         @(negedge clk);
         chk("R5 ctrl_word held", longint'(ctrl_word), my);
         chk("R6 ctrl_valid idle", longint'(ctrl_valid), 0);
      end
   endtask

   task automatic set_coef(input int a, input int b, input int g);
      pole_coef = 16'(a);
      zero_coef = 16'(b);
      gain_coef = 16'(g);
   endtask

   initial begin
      #200000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      do_reset();   // R1

      // R2 R3 R4 R5 R6: full input sweep under three coefficient sets, mixed gaps
      set_coef(-32767, -32700, 256);
      for (int v = -128; v < 128; v++) step(8'(v), v & 2);
      set_coef(-30000, -16384, 32767);
      for (int v = 127; v >= -128; v--) step(8'(v), (v & 1) * 3);
      set_coef(-1, -1, 1);
      for (int v = -128; v < 128; v++) step(8'(v), 0);

      // R7: near-integrator with largest gain, full-scale constant inputs
      do_reset();
      set_coef(-32767, -1, 32767);
      for (int i = 0; i < 3000; i++) step(-8'sd128, 0);
      for (int i = 0; i < 3000; i++) step(8'sd127, 0);
      chk("R7 state kept its sign under full-scale drive", (mw > 0) ? 1 : 0, 1);

      // R1: reset in the middle of a run clears everything
      for (int i = 0; i < 5; i++) step(8'sd100, 1);
      do_reset();
      step(8'sd50, 2);   // first strobe after reset: output still from cleared pipeline
      chk("R1 output zero on first strobe after reset", longint'(ctrl_word), 0);
      step(8'sd50, 2);
      step(-8'sd7, 4);

      // R2 R3: alternating signs with a changing pole
      set_coef(-20000, -30000, 1000);
      for (int i = 0; i < 64; i++) step((i % 2 == 0) ? 8'sd127 : -8'sd128, i % 3);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule